// File: doc/BRIEF.md
# Programmable Product-Term Array Evaluator

This block evaluates a small programmable logic array whose contents are loaded while the chip runs. The array holds a set of product-term rows. Each row carries one three-valued literal per input (input must be 1, input must be 0, or input absent) and one output-select bit per output. On every evaluation each row either fires or does not against the current input vector. Each output is the OR of its select bits over all rows that fire, so any number of rows, from none upward, may contribute at once.

Rows are written one at a time through a strobed write port that carries a row index, the literal vector and the output-select mask. A synchronous clear, and the reset, park every row in a code that can never fire. A parameter picks either a purely combinational output or an output register clocked on the rising edge. The storage grows only with the input, row and output counts. It does not depend on how complex the realised equations are.

Top module: `prog_pla_eval`

## Requirements
- R1: Each row holds one 2-bit literal per input, with the literal for input i in bits [2i+1:2i] of `wr_lits`. Code 00 = input ignored, 01 = input must be 1, 10 = input must be 0, 11 = the row can never fire. A row fires only when every literal is satisfied.
- R2: Bit j of a row's mask (`wr_mask[j]`) set to 1 puts that row's product term into output j; 0 leaves it out.
- R3: When no row fires, every output is 0.
- R4: When several rows fire, each output is the OR of the mask bits of all firing rows.
- R5: With `wr_en` high at a rising edge, row `wr_row` takes `wr_lits` and `wr_mask` and is in use from that edge on. All other rows keep their contents.
- R6: With `rst_n` low at a rising edge, every row is set to never-fire, so all outputs read 0 after reset until a row is written.
- R7: With `clr` high at a rising edge, every row is set to never-fire. A write in the same cycle is dropped.
- R8: With `REG_OUT` = 0, `out_vec` follows `in_vec` and the stored rows within the same cycle.
- R9: With `REG_OUT` = 1, `out_vec` is a register that takes, at each rising edge, the evaluation of the inputs and rows present just before that edge. Reset sets it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all rows to never-fire |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | ROW_W | Index of the row to write |
| wr_lits | input | 2*N_IN | Literal vector, 2 bits per input |
| wr_mask | input | N_OUT | Output-select mask for the row |
| in_vec | input | N_IN | Input vector to evaluate |
| out_vec | output | N_OUT | OR-plane result |

## Verification
A fixed set of five rows is evaluated on vectors that fire no row, exactly one row and three rows together. This separates correct OR merging from last-row-wins or first-match selection. Rows holding a single never-fire literal among don't-cares show whether code 11 is honoured, and single-literal rows check the polarity of codes 01 and 10. Random rows with every literal code, random masks and random inputs, mixed with clears, clears that collide with writes, and a reset in the middle of the run, are checked on a combinational and a registered instance against a bench model.

// File: rtl/pla_eval_pkg.sv
// Package: shared literal codes and the single-literal match rule for the
// programmable product-term array. Assumes 2-bit literals per input.
package pla_eval_pkg;

    localparam logic [1:0] LIT_ANY   = 2'b00;
    localparam logic [1:0] LIT_ONE   = 2'b01;
    localparam logic [1:0] LIT_ZERO  = 2'b10;
    localparam logic [1:0] LIT_NEVER = 2'b11;

    // True when one input bit satisfies one stored literal.
    function automatic logic lit_ok(input logic [1:0] code, input logic bit_in);
        logic ok;
        case (code)
            LIT_ANY:  ok = 1'b1;
            LIT_ONE:  ok = bit_in;
            LIT_ZERO: ok = ~bit_in;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pla_row_store.sv
// Module: pla_row_store
// Holds the array contents: per row a literal vector and an output mask.
// Reset (active low, synchronous) and clr park every row at never-fire;
// clr wins over a write in the same cycle. Assumes wr_row < N_ROW to write.
module pla_row_store #(
    parameter int N_IN  = 4,
    parameter int N_ROW = 8,
    parameter int N_OUT = 4,
    parameter int ROW_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [ROW_W-1:0]           wr_row,
    input  logic [2*N_IN-1:0]          wr_lits,
    input  logic [N_OUT-1:0]           wr_mask,
    output logic [N_ROW*2*N_IN-1:0]    lits_flat,
    output logic [N_ROW*N_OUT-1:0]     mask_flat
);
    localparam int LIT_W = 2 * N_IN;

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        logic [LIT_W-1:0] lits_q;
        logic [N_OUT-1:0] mask_q;
        logic             hit;

        // Decode whether this row is the write target.
        always_comb hit = wr_en && (wr_row == ROW_W'(r));

        // Row register: clear/reset to never-fire, else load on write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lits_q <= '1;
                mask_q <= '0;
            end else if (hit) begin
                lits_q <= wr_lits;
                mask_q <= wr_mask;
            end
        end

        // Flatten this row onto the shared buses.
        always_comb begin
            lits_flat[r*LIT_W +: LIT_W] = lits_q;
            mask_flat[r*N_OUT +: N_OUT] = mask_q;
        end
    end

endmodule

// File: rtl/pla_and_plane.sv
// Module: pla_and_plane
// Product-term plane: one fire bit per row, set when all literals of the
// row accept the input vector. Purely combinational.
module pla_and_plane
    import pla_eval_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_ROW = 8
) (
    input  logic [N_ROW*2*N_IN-1:0] lits_flat,
    input  logic [N_IN-1:0]         in_vec,
    output logic [N_ROW-1:0]        match_vec
);
    localparam int LIT_W = 2 * N_IN;

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        logic [N_IN-1:0] lit_hit;

        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            // Evaluate one literal of this row.
            always_comb lit_hit[i] = lit_ok(lits_flat[r*LIT_W + 2*i +: 2], in_vec[i]);
        end

        // Row fires when every literal is satisfied.
        always_comb match_vec[r] = &lit_hit;
    end

endmodule

// File: rtl/pla_or_plane.sv
// Module: pla_or_plane
// Sum plane: each output is the OR of its mask bit over all firing rows.
// Purely combinational; no firing row gives all zeros.
module pla_or_plane #(
    parameter int N_ROW = 8,
    parameter int N_OUT = 4
) (
    input  logic [N_ROW-1:0]       match_vec,
    input  logic [N_ROW*N_OUT-1:0] mask_flat,
    output logic [N_OUT-1:0]       or_res
);
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [N_ROW-1:0] col;

        for (genvar r = 0; r < N_ROW; r++) begin : g_row
            // Gate this row's mask bit for output j by its fire bit.
            always_comb col[r] = match_vec[r] & mask_flat[r*N_OUT + j];
        end

        // Merge the column.
        always_comb or_res[j] = |col;
    end

endmodule

// File: rtl/prog_pla_eval.sv
// Module: prog_pla_eval (top)
// Run-time programmable product-term array: row store, product plane,
// sum plane, and an optional output register chosen by REG_OUT.
// Assumes a single clock and a synchronous active-low reset.
module prog_pla_eval #(
    parameter int  N_IN    = 4,
    parameter int  N_ROW   = 8,
    parameter int  N_OUT   = 4,
    parameter bit  REG_OUT = 1'b0,
    localparam int ROW_W   = (N_ROW > 1) ? $clog2(N_ROW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [2*N_IN-1:0] wr_lits,
    input  logic [N_OUT-1:0]  wr_mask,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  out_vec
);
    logic [N_ROW*2*N_IN-1:0] lits_flat;
    logic [N_ROW*N_OUT-1:0]  mask_flat;
    logic [N_ROW-1:0]        match_vec;
    logic [N_OUT-1:0]        or_res;

    pla_row_store #(
        .N_IN(N_IN), .N_ROW(N_ROW), .N_OUT(N_OUT), .ROW_W(ROW_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
        .wr_row(wr_row), .wr_lits(wr_lits), .wr_mask(wr_mask),
        .lits_flat(lits_flat), .mask_flat(mask_flat)
    );

    pla_and_plane #(
        .N_IN(N_IN), .N_ROW(N_ROW)
    ) and_i (
        .lits_flat(lits_flat), .in_vec(in_vec), .match_vec(match_vec)
    );

    pla_or_plane #(
        .N_ROW(N_ROW), .N_OUT(N_OUT)
    ) or_i (
        .match_vec(match_vec), .mask_flat(mask_flat), .or_res(or_res)
    );

    if (REG_OUT) begin : g_reg
        logic [N_OUT-1:0] out_q;

        // Output register: capture the evaluation each rising edge.
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= or_res;
        end

        // Drive the port from the register.
        always_comb out_vec = out_q;
    end else begin : g_comb
        // Drive the port straight from the sum plane.
        always_comb out_vec = or_res;
    end

endmodule

// File: rtl/pla_eval_chk.sv
// Module: pla_eval_chk
// Assertion checker bound to prog_pla_eval. Observes ports and the
// buses between the store, product plane and sum plane.
module pla_eval_chk #(
    parameter int N_IN    = 4,
    parameter int N_ROW   = 8,
    parameter int N_OUT   = 4,
    parameter bit REG_OUT = 1'b0,
    parameter int ROW_W   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr,
    input logic                    wr_en,
    input logic [ROW_W-1:0]        wr_row,
    input logic [2*N_IN-1:0]       wr_lits,
    input logic [N_OUT-1:0]        wr_mask,
    input logic [N_IN-1:0]         in_vec,
    input logic [N_OUT-1:0]        out_vec,
    input logic [N_ROW*2*N_IN-1:0] lits_flat,
    input logic [N_ROW*N_OUT-1:0]  mask_flat,
    input logic [N_ROW-1:0]        match_vec,
    input logic [N_OUT-1:0]        or_res
);
    localparam int LIT_W = 2 * N_IN;

    // Per output: does any firing row select it (independent recompute).
    logic [N_OUT-1:0] col_any;
    always_comb begin
        col_any = '0;
        for (int j = 0; j < N_OUT; j++)
            for (int r = 0; r < N_ROW; r++)
                col_any[j] = col_any[j] | (match_vec[r] & mask_flat[r*N_OUT + j]);
    end

    assert_or_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        or_res == col_any);

    assert_none_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec == '0) |-> (or_res == '0));

    assert_reset_zero_R6: assert property (@(posedge clk)
        $rose(rst_n) |-> (out_vec == '0));

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !clr && wr_row == ROW_W'(r)) |=>
            (lits_flat[r*LIT_W +: LIT_W] == $past(wr_lits) &&
             mask_flat[r*N_OUT +: N_OUT] == $past(wr_mask)));

        assert_clear_rows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (lits_flat[r*LIT_W +: LIT_W] == '1));

        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            assert_never_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (lits_flat[r*LIT_W + 2*i +: 2] == 2'b11) |-> !match_vec[r]);
        end
    end

    if (REG_OUT) begin : g_reg_chk
        assert_reg_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_vec == $past(or_res)));
    end else begin : g_comb_chk
        assert_comb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(wr_en) && !$past(clr) && $past(rst_n) && $stable(in_vec))
            |-> $stable(out_vec));

        assert_clear_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (out_vec == '0));
    end

endmodule

bind prog_pla_eval pla_eval_chk #(
    .N_IN(N_IN), .N_ROW(N_ROW), .N_OUT(N_OUT), .REG_OUT(REG_OUT), .ROW_W(ROW_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_row(wr_row),
    .wr_lits(wr_lits), .wr_mask(wr_mask), .in_vec(in_vec), .out_vec(out_vec),
    .lits_flat(lits_flat), .mask_flat(mask_flat), .match_vec(match_vec),
    .or_res(or_res)
);

// File: tb/prog_pla_eval_tb_top.sv
// Bench for prog_pla_eval: a combinational instance (dut_i) and a
// registered instance (dut_reg_i) share stimulus; a bench model of the
// rows predicts both.
module prog_pla_eval_tb_top;
    localparam int N_IN = 4, N_ROW = 8, N_OUT = 4, ROW_W = 3;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, wr_en = 1'b0;
    logic [ROW_W-1:0]  wr_row = '0;
    logic [2*N_IN-1:0] wr_lits = '0;
    logic [N_OUT-1:0]  wr_mask = '0;
    logic [N_IN-1:0]   in_vec = '0;
    logic [N_OUT-1:0]  out_c, out_r;

    int checks = 0, failures = 0;
    logic [2*N_IN-1:0] m_lits [N_ROW];
    logic [N_OUT-1:0]  m_mask [N_ROW];

    always #4 clk = ~clk;

    prog_pla_eval #(.N_IN(N_IN), .N_ROW(N_ROW), .N_OUT(N_OUT), .REG_OUT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_row(wr_row),
        .wr_lits(wr_lits), .wr_mask(wr_mask), .in_vec(in_vec), .out_vec(out_c));

    prog_pla_eval #(.N_IN(N_IN), .N_ROW(N_ROW), .N_OUT(N_OUT), .REG_OUT(1'b1)) dut_reg_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_row(wr_row),
        .wr_lits(wr_lits), .wr_mask(wr_mask), .in_vec(in_vec), .out_vec(out_r));

    function automatic logic [N_OUT-1:0] model_eval(input logic [N_IN-1:0] v);
        logic [N_OUT-1:0] acc = '0;
        for (int r = 0; r < N_ROW; r++) begin
            logic fire = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                logic [1:0] c = m_lits[r][2*i +: 2];
                if (c == 2'b11 || (c == 2'b01 && !v[i]) || (c == 2'b10 && v[i])) fire = 1'b0;
            end
            if (fire) acc = acc | m_mask[r];
        end
        return acc;
    endfunction

    task automatic model_clear();
        for (int r = 0; r < N_ROW; r++) begin
            m_lits[r] = '1;
            m_mask[r] = '0;
        end
    endtask

    task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Write one row (optionally with clr in the same cycle).
    task automatic write_row(input int row, input logic [2*N_IN-1:0] l,
                             input logic [N_OUT-1:0] m, input logic with_clr);
        @(negedge clk);
        wr_en = 1'b1; wr_row = ROW_W'(row); wr_lits = l; wr_mask = m; clr = with_clr;
        @(posedge clk);
        #1;
        wr_en = 1'b0; clr = 1'b0;
        if (with_clr) model_clear();
        else begin
            m_lits[row] = l;
            m_mask[row] = m;
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(posedge clk);
        #1;
        clr = 1'b0;
        model_clear();
    endtask

    // Apply an input: check comb output same cycle, registered after edge.
    task automatic eval(input logic [N_IN-1:0] v, input string req_c, input string req_r);
        logic [N_OUT-1:0] e;
        @(negedge clk);
        in_vec = v;
        #1;
        e = model_eval(v);
        check(req_c, out_c, e);
        @(posedge clk);
        #1;
        check(req_r, out_r, e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h1f3c_a5e7));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: after reset every row is never-fire, outputs 0.
        eval(4'b0000, "R6 comb after reset", "R6 reg after reset");
        eval(4'b1111, "R6 comb after reset", "R6 reg after reset");

        // R1/R2/R3/R4: five example rows on abcd = in_vec[3:0].
        write_row(0, {2'b10, 2'b01, 2'b00, 2'b01}, 4'b0110, 1'b0); // 01-1
        write_row(1, {2'b00, 2'b01, 2'b00, 2'b01}, 4'b0101, 1'b0); // -1-1
        write_row(2, {2'b01, 2'b10, 2'b10, 2'b00}, 4'b0101, 1'b0); // 100-
        write_row(3, {2'b00, 2'b10, 2'b01, 2'b00}, 4'b0010, 1'b0); // -01-
        write_row(4, {2'b00, 2'b01, 2'b01, 2'b00}, 4'b0011, 1'b0); // -11-
        eval(4'b0001, "R3 comb no row fires", "R3 reg no row fires");
        check("R3 comb 0001 gives 0000", out_c, 4'b0000);
        eval(4'b1001, "R2 comb single row", "R2 reg single row");
        check("R2 comb 1001 gives 0101", out_c, 4'b0101);
        eval(4'b0111, "R4 comb three rows merged", "R4 reg three rows merged");
        check("R4 comb 0111 gives 0111", out_c, 4'b0111);
        for (int v = 0; v < 16; v++) eval(4'(v), "R4 comb sweep", "R9 reg sweep");

        // R1: a never-fire literal among don't-cares blocks the row.
        do_clear();
        write_row(5, {2'b00, 2'b11, 2'b00, 2'b00}, 4'b1111, 1'b0);
        for (int v = 0; v < 16; v++) eval(4'(v), "R1 comb never code", "R1 reg never code");
        // R1: single-literal polarity on input 0 and input 3.
        write_row(5, {2'b00, 2'b00, 2'b00, 2'b01}, 4'b0001, 1'b0);
        write_row(6, {2'b10, 2'b00, 2'b00, 2'b00}, 4'b1000, 1'b0);
        eval(4'b0001, "R1 comb polarity", "R1 reg polarity");
        check("R1 comb 0001 gives 1001", out_c, 4'b1001);
        eval(4'b1000, "R1 comb polarity", "R1 reg polarity");
        check("R1 comb 1000 gives 0000", out_c, 4'b0000);

        // R7: clear empties the array; a colliding write is dropped.
        do_clear();
        eval(4'b0001, "R7 comb after clear", "R7 reg after clear");
        write_row(2, '0, 4'b1111, 1'b1);
        eval(4'b1010, "R7 comb write dropped by clear", "R7 reg write dropped by clear");
        check("R7 comb collision gives 0000", out_c, 4'b0000);

        // R5/R8/R9: random rows, masks and inputs, with occasional clears.
        for (int k = 0; k < 300; k++) begin
            int sel = int'($urandom_range(0, 19));
            if (sel == 0) do_clear();
            else if (sel < 8)
                write_row(int'($urandom_range(0, N_ROW-1)), 8'($urandom), 4'($urandom), sel == 1);
            eval(4'($urandom), "R5 comb random", "R9 reg random");
        end

        // R6: reset mid-run clears written rows.
        write_row(7, '0, 4'b1010, 1'b0);
        do_reset();
        eval(4'b0110, "R6 comb reset mid-run", "R6 reg reset mid-run");
        check("R6 comb mid-run gives 0000", out_c, 4'b0000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule